// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns device-side virtual addresses into physical addresses. Each request is looked up in a small fully associative translation cache. On a miss the block reads two entries from a two-level table in memory, returns the physical address, and stores the result in the cache. The first-level table is found through a frame number on a configuration input. Its entry gives the frame of a second-level table. The second-level entry gives the frame of the data page. The block does no table construction, permission checking or fault reporting.

Table entries have no valid flag. Every index always resolves to some frame, and software points unused entries at a shared placeholder frame. Only one request is in service at a time. A single-cycle invalidate strobe empties the entire cache. If the strobe arrives while a walk is in progress, the walk still answers its request but its result is not stored in the cache.

Top module: `iova_walker`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_valid` is 0.
- R2: On a miss, the first memory read goes to address (`root_frame` << 12) + 4 × `req_va[31:22]`.
- R3: The second memory read goes to address (F1 << 12) + 4 × `req_va[21:12]`, where F1 is bits [26:0] of the first read's data. Bits [31:27] of the data are ignored.
- R4: After the second read's data arrives, `rsp_valid` is 1 for exactly one cycle, with `rsp_pa` = {F2[26:0], `req_va[11:0]`}, where F2 is the second read's data.
- R5: From the cycle after a request is accepted until the cycle its response is shown, `req_ready` is 0, so at most one walk is in progress.
- R6: A request whose page (`req_va[31:12]`) is held in the cache is answered with no memory read. Its `rsp_valid` rises on the second clock edge after acceptance.
- R7: An index that the tables point at the placeholder frame gives a normal response carrying that frame. No fault is produced.
- R8: A one-cycle pulse on `inval` empties the whole cache. A page that was cached before the pulse needs two memory reads again. An `inval` pulse in a lookup cycle forces that lookup to miss.
- R9: If `inval` is high in any cycle of a walk, that walk still returns the correct address but stores nothing. The next request for the same page walks again.
- R10: The cache holds 8 pages and replaces them in round-robin order. Invalidation does not reset the replacement pointer, and a hit does not move it.
- R11: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, `mem_rd_valid` stays 1 and `mem_rd_addr` stays unchanged.
- R12: The result is correct for any number of `mem_rd_ready` stall cycles and any read-data delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 39 | Translated physical address |
| mem_rd_valid | output | 1 | Table-entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 39 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry value; low 27 bits are a frame number |
| root_frame | input | 27 | Frame number of the first-level table |
| inval | input | 1 | Empty the whole cache |

## Verification
Some properties are checked on every cycle:
- the request port stays stalled through a walk;
- a pending read keeps its address;
- a response is a single-cycle pulse;
- no page ever matches two cache slots;
- an invalidate leaves no valid slot.

Other behaviour only the directed scenarios can show:
- read address formation and correct translations;
- placeholder mappings and hit latency;
- a walk whose result is discarded after an invalidate;
- the round-robin eviction order;
- results under memory stalls.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT
  } walk_state_e;
endpackage

// File: rtl/iova_tlb.sv
module iova_tlb #(
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 27,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inval,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]   valid_q;
  logic [DEPTH-1:0]   match;
  logic [PTR_W-1:0]   ptr_q;
  logic [VPN_W-1:0]   tag_q   [DEPTH];
  logic [FRAME_W-1:0] frame_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  assign lk_hit = |match;

  always_comb begin
    lk_frame = '0;
    for (int k = 0; k < DEPTH; k++)
      if (match[k]) lk_frame = lk_frame | frame_q[k];
  end

  // Valid bits and replacement pointer; invalidate wins over a fill.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (inval) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // Payload storage, no reset.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[ptr_q]   <= fill_vpn;
      frame_q[ptr_q] <= fill_frame;
    end
  end

  assert_single_match_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  assert_inval_empties_R8: assert property (@(posedge clk) disable iff (rst)
    inval |=> (valid_q == '0));
endmodule

// File: rtl/iova_walk_ctl.sv
module iova_walk_ctl
  import iova_walk_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10,
  parameter int FRAME_W    = 27,
  parameter int PTE_W      = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [PAGE_SHIFT+2*IDX_W-1:0]     req_va,
  output logic                              rsp_valid,
  output logic [FRAME_W+PAGE_SHIFT-1:0]     rsp_pa,
  output logic                              mem_rd_valid,
  input  logic                              mem_rd_ready,
  output logic [FRAME_W+PAGE_SHIFT-1:0]     mem_rd_addr,
  input  logic                              mem_rsp_valid,
  input  logic [PTE_W-1:0]                  mem_rsp_data,
  input  logic [FRAME_W-1:0]                root_frame,
  input  logic                              inval,
  output logic [2*IDX_W-1:0]                lk_vpn,
  input  logic                              lk_hit,
  input  logic [FRAME_W-1:0]                lk_frame,
  output logic                              fill_en,
  output logic [2*IDX_W-1:0]                fill_vpn,
  output logic [FRAME_W-1:0]                fill_frame
);
  localparam int VA_W      = PAGE_SHIFT + 2 * IDX_W;
  localparam int PA_W      = FRAME_W + PAGE_SHIFT;
  localparam int ENT_SHIFT = PAGE_SHIFT - IDX_W;

  walk_state_e         state_q;
  logic [VA_W-1:0]     va_q;
  logic                poison_q;
  logic                rsp_valid_q;
  logic [PA_W-1:0]     rsp_pa_q;
  logic [PA_W-1:0]     addr_q;
  logic [IDX_W-1:0]    l1_idx, l2_idx;
  logic [FRAME_W-1:0]  ent_frame;
  logic                unused_pte_bits;

  assign l1_idx    = va_q[VA_W-1 -: IDX_W];
  assign l2_idx    = va_q[PAGE_SHIFT +: IDX_W];
  assign ent_frame = mem_rsp_data[FRAME_W-1:0];
  assign unused_pte_bits = ^mem_rsp_data[PTE_W-1:FRAME_W];

  assign lk_vpn       = va_q[VA_W-1:PAGE_SHIFT];
  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_rd_addr  = addr_q;
  assign rsp_valid    = rsp_valid_q;
  assign rsp_pa       = rsp_pa_q;

  assign fill_en    = (state_q == ST_L2_WAIT) && mem_rsp_valid && !poison_q && !inval;
  assign fill_vpn   = va_q[VA_W-1:PAGE_SHIFT];
  assign fill_frame = ent_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      poison_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_pa_q    <= '0;
      addr_q      <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (state_q != ST_IDLE && state_q != ST_LOOK && inval) poison_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_va;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          poison_q <= 1'b0;
          if (lk_hit && !inval) begin
            rsp_valid_q <= 1'b1;
            rsp_pa_q    <= {lk_frame, va_q[PAGE_SHIFT-1:0]};
            state_q     <= ST_IDLE;
          end else begin
            addr_q  <= {root_frame, l1_idx, {ENT_SHIFT{1'b0}}};
            state_q <= ST_L1_REQ;
          end
        end
        ST_L1_REQ: if (mem_rd_ready) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          addr_q  <= {ent_frame, l2_idx, {ENT_SHIFT{1'b0}}};
          state_q <= ST_L2_REQ;
        end
        ST_L2_REQ: if (mem_rd_ready) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          rsp_valid_q <= 1'b1;
          rsp_pa_q    <= {ent_frame, va_q[PAGE_SHIFT-1:0]};
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_accept_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_fetch_blocks_req_R5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  assert_fetch_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/iova_walker.sv
module iova_walker #(
  parameter int PAGE_SHIFT = 12,
  parameter int IDX_W      = 10,
  parameter int FRAME_W    = 27,
  parameter int PTE_W      = 32,
  parameter int TLB_DEPTH  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [PAGE_SHIFT+2*IDX_W-1:0] req_va,
  output logic                          rsp_valid,
  output logic [FRAME_W+PAGE_SHIFT-1:0] rsp_pa,
  output logic                          mem_rd_valid,
  input  logic                          mem_rd_ready,
  output logic [FRAME_W+PAGE_SHIFT-1:0] mem_rd_addr,
  input  logic                          mem_rsp_valid,
  input  logic [PTE_W-1:0]              mem_rsp_data,
  input  logic [FRAME_W-1:0]            root_frame,
  input  logic                          inval
);
  localparam int VPN_W = 2 * IDX_W;

  logic [VPN_W-1:0]   lk_vpn, fill_vpn;
  logic               lk_hit, fill_en;
  logic [FRAME_W-1:0] lk_frame, fill_frame;

  iova_walk_ctl #(
    .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W), .FRAME_W(FRAME_W), .PTE_W(PTE_W)
  ) u_ctl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .root_frame(root_frame), .inval(inval),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_frame(fill_frame)
  );

  iova_tlb #(
    .VPN_W(VPN_W), .FRAME_W(FRAME_W), .DEPTH(TLB_DEPTH)
  ) u_tlb (
    .clk(clk), .rst(rst), .inval(inval),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_frame(fill_frame)
  );
endmodule

// File: tb/iova_walker_bench.sv
`timescale 1ns/1ps
module iova_walker_bench;
  localparam logic [26:0] ROOT     = 27'h0000100;
  localparam logic [26:0] L2BASE   = 27'h0000200;
  localparam logic [26:0] DUMMY_L2 = 27'h00000FF;
  localparam logic [26:0] DUMMY_PG = 27'h00000FE;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic [38:0] rsp_pa;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b1;
  logic [38:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [26:0] root_frame = ROOT;
  logic        inval = 1'b0;

  iova_walker u_iova_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .root_frame(root_frame), .inval(inval)
  );

  int n_checks = 0, n_fail = 0;
  int reads = 0;
  int mem_lat = 0;
  bit stall_mode = 1'b0;
  int cyc = 0;
  logic [38:0] addr_log [0:7];
  bit busy = 1'b0;
  int cnt = 0;
  logic [38:0] pend_addr = '0;

  function automatic bit l1_mapped(input logic [9:0] i);
    return (i < 10'd4) || (i == 10'h3FF);
  endfunction

  function automatic logic [26:0] l2_frame_of(input logic [9:0] i);
    return l1_mapped(i) ? L2BASE + 27'(i) : DUMMY_L2;
  endfunction

  function automatic logic [26:0] page_frame_of(input logic [9:0] i, input logic [9:0] j);
    if (l1_mapped(i) && !j[0]) return 27'h0040000 + 27'(i) * 27'd1024 + 27'(j);
    return DUMMY_PG;
  endfunction

  // Memory model of table contents; upper entry bits carry junk.
  function automatic logic [31:0] mem_value(input logic [38:0] a);
    logic [26:0] f = a[38:12];
    logic [9:0]  x = a[11:2];
    if (f == ROOT) return {5'b10101, l2_frame_of(x)};
    if (f >= L2BASE && f < L2BASE + 27'd1024) return {5'b11011, page_frame_of(10'(f - L2BASE), x)};
    if (f == DUMMY_L2) return {5'b10011, DUMMY_PG};
    return 32'hDEADBEEF;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid = 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_value(pend_addr);
        busy = 1'b0;
      end else cnt = cnt - 1;
    end
    mem_rd_ready = stall_mode ? ((cyc % 3) == 2) : 1'b1;
    if (mem_rd_valid && mem_rd_ready && !rst) begin
      addr_log[reads % 8] = mem_rd_addr;
      pend_addr = mem_rd_addr;
      reads = reads + 1;
      busy = 1'b1;
      cnt = mem_lat;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  // One translation; inval_at >= 0 pulses inval once that many reads are done.
  task automatic translate(input logic [31:0] va, input int exp_reads, input string rq,
                           input int inval_at, output int lat);
    int base = reads;
    bit pulsed = 1'b0;
    logic [38:0] exp_pa = {page_frame_of(va[31:22], va[21:12]), va[11:0]};
    lat = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0; lat = 1;
    chk(req_ready == 1'b0, "R5", "ready after accept", 64'(req_ready), 64'd0);
    while (!rsp_valid && lat < 400) begin
      if (inval) inval = 1'b0;
      if (inval_at >= 0 && !pulsed && reads - base == inval_at) begin
        inval = 1'b1; pulsed = 1'b1;
      end
      @(negedge clk);
      lat++;
      if (!rsp_valid && req_ready) chk(1'b0, "R5", "ready during walk", 64'd1, 64'd0);
    end
    inval = 1'b0;
    chk(rsp_valid == 1'b1, rq, "response seen", 64'(rsp_valid), 64'd1);
    chk(rsp_pa == exp_pa, rq, "physical address", 64'(rsp_pa), 64'(exp_pa));
    chk(reads - base == exp_reads, rq, "memory reads", 64'(reads - base), 64'(exp_reads));
    if (exp_reads == 2 && reads - base == 2) begin
      chk(addr_log[base % 8] == {ROOT, va[31:22], 2'b00}, "R2", "first-level address",
          64'(addr_log[base % 8]), 64'({ROOT, va[31:22], 2'b00}));
      chk(addr_log[(base + 1) % 8] == {l2_frame_of(va[31:22]), va[21:12], 2'b00}, "R3",
          "second-level address", 64'(addr_log[(base + 1) % 8]),
          64'({l2_frame_of(va[31:22]), va[21:12], 2'b00}));
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R4", "response one cycle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic pulse_inval;
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
  endtask

  function automatic logic [31:0] mk_va(input logic [9:0] i, input logic [9:0] j, input logic [11:0] o);
    return {i, j, o};
  endfunction

  task automatic t_reset;  // R1
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp in reset", 64'(rsp_valid), 64'd0);
    chk(mem_rd_valid == 1'b0, "R1", "mem in reset", 64'(mem_rd_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && !rsp_valid && !mem_rd_valid, "R1", "state after reset",
        64'({req_ready, rsp_valid, mem_rd_valid}), 64'b100);
  endtask

  task automatic t_miss_then_hit;  // R2 R3 R4 R6
    int lat;
    translate(mk_va(10'd1, 10'd4, 12'hABC), 2, "R4", -1, lat);
    translate(mk_va(10'd1, 10'd4, 12'h123), 0, "R6", -1, lat);
    chk(lat == 2, "R6", "hit latency", 64'(lat), 64'd2);
    translate(mk_va(10'h3FF, 10'h3FE, 12'hFFF), 2, "R2", -1, lat);
  endtask

  task automatic t_placeholder;  // R7
    int lat;
    translate(mk_va(10'd5, 10'd7, 12'h010), 2, "R7", -1, lat);
    translate(mk_va(10'd2, 10'd9, 12'h020), 2, "R7", -1, lat);
  endtask

  task automatic t_invalidate;  // R8
    int lat;
    translate(mk_va(10'd0, 10'd6, 12'h004), 2, "R8", -1, lat);
    translate(mk_va(10'd0, 10'd6, 12'h008), 0, "R8", -1, lat);
    pulse_inval();
    translate(mk_va(10'd0, 10'd6, 12'h00C), 2, "R8", -1, lat);
  endtask

  task automatic t_inval_in_walk;  // R9
    int lat;
    mem_lat = 3;
    translate(mk_va(10'd3, 10'd12, 12'h044), 2, "R9", 1, lat);
    translate(mk_va(10'd3, 10'd12, 12'h048), 2, "R9", -1, lat);
    translate(mk_va(10'd3, 10'd12, 12'h04C), 0, "R9", -1, lat);
    mem_lat = 0;
  endtask

  task automatic t_round_robin;  // R10
    int lat;
    pulse_inval();
    for (int p = 0; p < 9; p++)
      translate(mk_va(10'd2, 10'(2 * p), 12'h000), 2, "R10", -1, lat);
    translate(mk_va(10'd2, 10'd2, 12'h000), 0, "R10", -1, lat);
    translate(mk_va(10'd2, 10'd0, 12'h000), 2, "R10", -1, lat);
    translate(mk_va(10'd2, 10'd4, 12'h000), 0, "R10", -1, lat);
    translate(mk_va(10'd2, 10'd2, 12'h000), 2, "R10", -1, lat);
  endtask

  task automatic t_stalls;  // R11 R12
    int lat;
    stall_mode = 1'b1; mem_lat = 5;
    translate(mk_va(10'd1, 10'd40, 12'h3C0), 2, "R12", -1, lat);
    translate(mk_va(10'h3FF, 10'd0, 12'h001), 2, "R11", -1, lat);
    stall_mode = 1'b0; mem_lat = 0;
  endtask

  initial begin
    t_reset();
    t_miss_then_hit();
    t_placeholder();
    t_invalidate();
    t_inval_in_walk();
    t_round_robin();
    t_stalls();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule